// File: doc/BRIEF.md
# Video Memory Aperture Decoder

This block sits between a 24-bit host memory bus and the display memory of a video controller. On every host memory cycle it decides whether the cycle belongs to the display memory. When it does, it raises a hit signal and produces a 20-bit display memory address. A small register port lets software program the decode.

The block has two decode modes. In banked mode it claims only the legacy graphics window inside the first megabyte of host space. The four upper display address bits then come from a bank register, which holds separate nibbles for reads and for writes. In linear mode it claims a whole 1 MB aperture whose position is chosen by the four top host address bits. Linear mode is only honoured when the memory-map field selects the full 128 KB window; with any other map setting the block stays in banked decoding.

The hit and address outputs are combinational. They follow the current host address, valid and write inputs and the current register contents. A register write takes effect at the next rising clock edge.

Top module: `vid_aperture_dec`

## Requirements
- R1: After reset all four registers read back as 0, so the block is in banked mode with map field 00.
- R2: The register select `cfg_sel` chooses which register is written and which is read back:
  - 0 selects the bank register: bits 3:0 are the write bank and bits 7:4 are the read bank.
  - 1 selects the control register, with the linear enable at bit 4.
  - 2 selects the memory-map field at bits 3:2.
  - 3 selects the aperture base at bits 3:0.
  Bits that are not stored read back as 0.
- R3: In banked mode a hit needs the host address to fall inside the window chosen by the map field: 00 selects A0000h–BFFFFh, 01 selects A0000h–AFFFFh, 10 selects B0000h–B7FFFh and 11 selects B8000h–BFFFFh.
- R4: In banked mode no hit occurs unless host address bits 23:20 are all zero.
- R5: On a banked hit the display address is {bank nibble, host address 15:0}. A write cycle (`host_wr`=1) uses the write bank and a read cycle uses the read bank.
- R6: In linear mode a hit occurs exactly when host address bits 23:20 equal the aperture base.
- R7: On a linear hit the display address equals host address bits 19:0.
- R8: While the map field is not 00, the linear enable has no effect and decoding is banked.
- R9: When `host_valid` is 0 or the cycle misses, `hit` is 0 and the display address is 0.
- R10: A register write becomes visible in the decode and in read-back at the rising edge on which `cfg_we` is sampled high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| host_valid | input | 1 | Host memory cycle present |
| host_wr | input | 1 | 1 for a write cycle, 0 for a read cycle |
| host_addr | input | 24 | Host memory address |
| hit | output | 1 | Cycle is claimed by display memory |
| disp_addr | output | 20 | Display memory address |

## Verification
The assertions assume that the host inputs are stable from the moment they are applied until the next rising edge. They also assume that register writes arrive only as single-cycle strobes, so the register state they read is settled when the decode is sampled. The stimulus drives every input on the falling edge and holds it for a full period. It samples the outputs a quarter period later, which keeps the host cycle well clear of the register-update edge. Random register settings and addresses are drawn so that map values, bank nibbles and aperture bases change between probes. Separate directed probes sit on each window boundary.

// File: rtl/vid_aperture_dec.sv
module vid_aperture_dec #(
  parameter int HOST_AW = 24,
  parameter int DISP_AW = 20,
  parameter int BANK_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic               host_valid,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  output logic               hit,
  output logic [DISP_AW-1:0] disp_addr
);
  localparam int TOP_W = HOST_AW - DISP_AW;
  localparam int LOW_W = DISP_AW - BANK_W;

  logic [2*BANK_W-1:0] bank_q;
  logic                lin_q;
  logic [1:0]          map_q;
  logic [TOP_W-1:0]    base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      lin_q  <= 1'b0;
      map_q  <= 2'b00;
      base_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: bank_q <= cfg_wdata[2*BANK_W-1:0];
        2'd1: lin_q  <= cfg_wdata[4];
        2'd2: map_q  <= cfg_wdata[3:2];
        default: base_q <= cfg_wdata[TOP_W-1:0];
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      2'd0: cfg_rdata[2*BANK_W-1:0] = bank_q;
      2'd1: cfg_rdata[4] = lin_q;
      2'd2: cfg_rdata[3:2] = map_q;
      default: cfg_rdata[TOP_W-1:0] = base_q;
    endcase
  end

  wire             lin_mode = lin_q && (map_q == 2'b00);
  wire [TOP_W-1:0] top_bits = host_addr[HOST_AW-1:DISP_AW];
  wire [4:0]       win_bits = host_addr[DISP_AW-1:DISP_AW-5];

  logic in_window;
  always_comb begin
    case (map_q)
      2'b00:   in_window = win_bits[4:2] == 3'b101;
      2'b01:   in_window = win_bits[4:1] == 4'b1010;
      2'b10:   in_window = win_bits == 5'b10110;
      default: in_window = win_bits == 5'b10111;
    endcase
  end

  wire              lin_hit  = lin_mode && (top_bits == base_q);
  wire              bank_hit = !lin_mode && (top_bits == '0) && in_window;
  wire [BANK_W-1:0] nib      = host_wr ? bank_q[BANK_W-1:0] : bank_q[2*BANK_W-1:BANK_W];

  assign hit = host_valid && (lin_hit || bank_hit);

  always_comb begin
    if (!hit)          disp_addr = '0;
    else if (lin_mode) disp_addr = host_addr[DISP_AW-1:0];
    else               disp_addr = {nib, host_addr[LOW_W-1:0]};
  end
endmodule

// File: rtl/vid_aperture_chk.sv
module vid_aperture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [7:0]  cfg_wdata,
  input logic        host_valid,
  input logic        host_wr,
  input logic [23:0] host_addr,
  input logic        hit,
  input logic [19:0] disp_addr,
  input logic [7:0]  bank_q,
  input logic        lin_q,
  input logic [1:0]  map_q
);
  wire banked = !(lin_q && map_q == 2'b00);

  // R9
  no_valid_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |-> (!hit && disp_addr == 20'h0));

  // R4
  banked_first_mb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && banked) |-> host_addr[23:20] == 4'h0);

  // R3
  banked_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && banked) |-> host_addr[19:17] == 3'b101);

  // R5
  banked_write_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && banked && host_wr) |-> disp_addr[19:16] == bank_q[3:0]);

  // R5
  banked_read_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && banked && !host_wr) |-> disp_addr[19:16] == bank_q[7:4]);

  // R7
  linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && host_addr[23:20] != 4'h0) |-> disp_addr == host_addr[19:0]);

  // R10
  bank_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0) |=> bank_q == $past(cfg_wdata));
endmodule

bind vid_aperture_dec vid_aperture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .host_valid(host_valid), .host_wr(host_wr),
  .host_addr(host_addr), .hit(hit), .disp_addr(disp_addr),
  .bank_q(bank_q), .lin_q(lin_q), .map_q(map_q)
);

// File: tb/sim_vid_aperture_dec.sv
`timescale 1ns/1ps
module sim_vid_aperture_dec;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic        host_valid = 0;
  logic        host_wr = 0;
  logic [23:0] host_addr = 0;
  logic        hit;
  logic [19:0] disp_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int m_bank = 0, m_lin = 0, m_map = 0, m_base = 0;

  always #10 clk = ~clk;

  vid_aperture_dec u0 (.*);

  task automatic report(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(int sel);
    case (sel)
      0: return m_bank;
      1: return m_lin * 16;
      2: return m_map * 4;
      default: return m_base;
    endcase
  endfunction

  task automatic wr_reg(int sel, int data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel[1:0]; cfg_wdata = data[7:0];
    #5 report("R10 before edge", cfg_rdata, exp_rd(sel));
    @(posedge clk);
    case (sel)
      0: m_bank = data & 255;
      1: m_lin = (data >> 4) & 1;
      2: m_map = (data >> 2) & 3;
      default: m_base = data & 15;
    endcase
    @(negedge clk);
    cfg_we = 0;
    #5 report("R2/R10 readback", cfg_rdata, exp_rd(sel));
  endtask

  task automatic probe(string req, int addr, bit valid, bit wr);
    int lo, hi, e_hit, e_addr;
    bit lin;
    @(negedge clk);
    host_addr = addr[23:0]; host_valid = valid; host_wr = wr;
    #5;
    lin = (m_lin == 1) && (m_map == 0);
    case (m_map)
      0: begin lo = 'hA0000; hi = 'hBFFFF; end
      1: begin lo = 'hA0000; hi = 'hAFFFF; end
      2: begin lo = 'hB0000; hi = 'hB7FFF; end
      default: begin lo = 'hB8000; hi = 'hBFFFF; end
    endcase
    if (!valid) e_hit = 0;
    else if (lin) e_hit = ((addr / 'h100000) == m_base) ? 1 : 0;
    else e_hit = (addr >= lo && addr <= hi) ? 1 : 0;
    if (e_hit == 0) e_addr = 0;
    else if (lin) e_addr = addr % 'h100000;
    else e_addr = (wr ? (m_bank % 16) : (m_bank / 16)) * 'h10000 + addr % 'h10000;
    report({req, " hit"}, hit, e_hit);
    report({req, " addr"}, disp_addr, e_addr);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); cfg_sel = s[1:0]; #5 report("R1 reset readback", cfg_rdata, 0);
    end
    probe("R1 reset decode", 'h0A1234, 1, 0);

    wr_reg(0, 'h73);
    wr_reg(1, 'hEF);
    wr_reg(2, 'hFF);
    wr_reg(3, 'hF9);
    wr_reg(1, 0); wr_reg(2, 0);

    probe("R3 map00 low edge", 'h0A0000, 1, 1);
    probe("R3 map00 high edge", 'h0BFFFF, 1, 0);
    probe("R3 below window", 'h09FFFF, 1, 1);
    probe("R3 above window", 'h0C0000, 1, 0);
    probe("R5 write bank", 'h0A5678, 1, 1);
    probe("R5 read bank", 'h0B5678, 1, 0);
    probe("R4 upper bits set", 'h1A0000, 1, 1);
    probe("R4 top nibble", 'hFB0000, 1, 0);
    probe("R9 not valid", 'h0A0000, 0, 1);
    wr_reg(2, 'h04);
    probe("R3 map01 in", 'h0AFFFF, 1, 1);
    probe("R3 map01 out", 'h0B0000, 1, 1);
    wr_reg(2, 'h08);
    probe("R3 map10 in", 'h0B7FFF, 1, 0);
    probe("R3 map10 out", 'h0B8000, 1, 0);
    wr_reg(2, 'h0C);
    probe("R3 map11 in", 'h0B8000, 1, 1);
    probe("R3 map11 out", 'h0AFFFF, 1, 1);

    wr_reg(1, 'h10);
    probe("R8 linear ignored", 'h5B8000, 1, 1);
    probe("R8 banked still", 'h0B9000, 1, 0);
    wr_reg(3, 5);
    probe("R8 base ignored", 'h512345, 1, 0);
    wr_reg(2, 0);
    probe("R6 linear hit", 'h512345, 1, 0);
    probe("R7 linear pass", 'h5FFFFF, 1, 1);
    probe("R6 linear miss", 'h412345, 1, 1);
    probe("R6 legacy window miss", 'h0A0000, 1, 0);
    probe("R9 linear not valid", 'h500000, 0, 0);
    wr_reg(3, 0);
    probe("R6 base zero", 'h012345, 1, 1);

    for (int i = 0; i < 400; i++) begin
      if (i % 8 == 0) wr_reg($urandom_range(0, 3), $urandom_range(0, 255));
      probe("R3-R9 random", (i % 3 == 0) ? $urandom_range(0, 'hFFFFFF)
            : ($urandom_range(0, 15) * 'h100000 + $urandom_range('hA0000, 'hBFFFF)),
            $urandom_range(0, 7) != 0, $urandom_range(0, 1));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule